// File: doc/BRIEF.md
# Supply Monitor Control and Status Register

This block is one 8-bit control and status register for a supply-voltage supervisor. Two digital comparator outputs come in from an analog front end: a detect level, for a deep brown-out, and a warning level, for an early drop. Both are asynchronous, so each passes through a two-flop synchronizer. A stop-mode indication also comes in. The block drives three outputs: a warning interrupt request, a low-voltage reset request for the system reset sequencer, and an enable for the bandgap reference buffer.

The warning flag is sticky. Software can clear it with an acknowledge write, but the clear only takes effect once the warning condition has gone away. The detect enable and detect reset enable are write-once. The first register write after reset sets an internal lock, and from then on both bits are frozen until the next reset. While the system is in stop mode, detect events are masked unless the stop enable bit is set.

The CPU side is a plain bus. It has an address-match select, read and write strobes, write data and combinational read data.

Top module: `lvmon_ctrl`

## Requirements
- R1: After reset the register reads 0x1C. Bits 4, 3 and 2 are 1 and all other bits are 0. `warn_irq_o`, `lv_rst_req_o` and `bg_buf_en_o` are all 0.
- R2: The warning flag (read bit 7) sets while the synchronized warning input is 1. This also applies when the input is already 1 as reset is released.
- R3: The warning flag stays 1 after the warning input returns to 0. Only an acknowledge clears it.
- R4: A write with bit 6 = 1 clears the warning flag only if the synchronized warning input is 0. If the input is still 1, the write leaves the flag at 1.
- R5: `warn_irq_o` is 1 exactly when the warning flag is 1 and the interrupt enable (bit 5) is 1.
- R6: The first write after reset sets a lock. Bits 2 (detect enable) and 4 (detect reset enable) take the value of that write only. Every later write leaves them unchanged until reset.
- R7: `lv_rst_req_o` is 1 only while the synchronized detect input is 1 and both bit 2 and bit 4 are 1.
- R8: While `stop_i` is 1, `lv_rst_req_o` is held at 0 unless the stop enable (bit 3) is 1. When `stop_i` is 0, bit 3 has no effect.
- R9: Bits 5, 3 and 0 can be written at any time. Bit 0 drives `bg_buf_en_o`.
- R10: Bits 6 and 1 always read 0. Writing bit 7 has no effect on the flag.
- R11: `rdata_o` is 0 unless both `sel_i` and `rd_i` are 1.
- R12: Each comparator input reaches its consumer only after two synchronizing flops. `lv_rst_req_o` follows `lvd_cmp_i` after the second rising edge. The warning flag reads 1 after the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Register address match |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| lvd_cmp_i | input | 1 | Asynchronous low-voltage detect comparator |
| lvw_cmp_i | input | 1 | Asynchronous low-voltage warning comparator |
| stop_i | input | 1 | System is in stop mode |
| warn_irq_o | output | 1 | Warning interrupt request |
| lv_rst_req_o | output | 1 | Low-voltage reset request |
| bg_buf_en_o | output | 1 | Bandgap buffer enable |

## Verification
The bench acknowledges the flag while the warning input is still high. A design that cleared the flag unconditionally would lose a live warning there.

It makes a first write that clears the write-once bits, then tries to set them again. A lock that keyed on the bit values, or that was missing, would let the second write through.

It raises the detect input in stop mode with the stop enable cleared, and again with detect reset enable written to 0. A design that leaked a reset request in either case would fail.

It times the flag and the reset request edge by edge. A missing or extra synchronizer stage shows up as a one-cycle shift. A warning present at reset release must still set the flag.

// File: rtl/lvmon_pkg.sv
package lvmon_pkg;
  localparam int unsigned DW       = 8;
  localparam int unsigned B_FLAG   = 7;
  localparam int unsigned B_ACK    = 6;
  localparam int unsigned B_IRQEN  = 5;
  localparam int unsigned B_RSTEN  = 4;
  localparam int unsigned B_STOPEN = 3;
  localparam int unsigned B_DETEN  = 2;
  localparam int unsigned B_BGEN   = 0;

  typedef struct packed {
    logic irq_en;
    logic rst_en;
    logic stop_en;
    logic det_en;
    logic bg_en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{irq_en: 1'b0, rst_en: 1'b1, stop_en: 1'b1,
                                 det_en: 1'b1, bg_en: 1'b0};
endpackage

// File: rtl/lvmon_sync.sv
module lvmon_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lvmon_cfg.sv
module lvmon_cfg
  import lvmon_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_stb_i,
  input  ctrl_t wval_i,
  output ctrl_t cfg_o,
  output logic  lock_o
);
  ctrl_t cfg_q;
  logic  lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CTRL_RST;
      lock_q <= 1'b0;
    end else if (wr_stb_i) begin
      lock_q        <= 1'b1;
      cfg_q.irq_en  <= wval_i.irq_en;
      cfg_q.stop_en <= wval_i.stop_en;
      cfg_q.bg_en   <= wval_i.bg_en;
      if (!lock_q) begin
        cfg_q.det_en <= wval_i.det_en;
        cfg_q.rst_en <= wval_i.rst_en;
      end
    end
  end

  assign cfg_o  = cfg_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/lvmon_warn.sv
module lvmon_warn (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic warn_s_i,
  input  logic ack_i,
  output logic flag_o
);
  logic flag_q;

  // a live warning always wins over an acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (warn_s_i) flag_q <= 1'b1;
    else if (ack_i)    flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/lvmon_ctrl.sv
module lvmon_ctrl
  import lvmon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          lvd_cmp_i,
  input  logic          lvw_cmp_i,
  input  logic          stop_i,
  output logic          warn_irq_o,
  output logic          lv_rst_req_o,
  output logic          bg_buf_en_o
);
  logic [1:0] cmp_s;
  logic       lvd_s, lvw_s;
  logic       wr_stb, ack_stb;
  logic       lock, warn_flag, det_live;
  ctrl_t      wval, cfg;
  logic       unused_wbits;

  lvmon_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({lvd_cmp_i, lvw_cmp_i}),
    .q_o   (cmp_s)
  );
  assign lvd_s = cmp_s[1];
  assign lvw_s = cmp_s[0];

  assign wr_stb  = sel_i & wr_i;
  assign ack_stb = wr_stb & wdata_i[B_ACK];
  assign wval    = '{irq_en: wdata_i[B_IRQEN], rst_en: wdata_i[B_RSTEN],
                     stop_en: wdata_i[B_STOPEN], det_en: wdata_i[B_DETEN],
                     bg_en: wdata_i[B_BGEN]};
  assign unused_wbits = ^{wdata_i[B_FLAG], wdata_i[1]};

  lvmon_cfg i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_stb_i(wr_stb),
    .wval_i  (wval),
    .cfg_o   (cfg),
    .lock_o  (lock)
  );

  lvmon_warn i_warn (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .warn_s_i(lvw_s),
    .ack_i   (ack_stb),
    .flag_o  (warn_flag)
  );

  // detect path is live when enabled, and in stop only with stop enable
  assign det_live     = cfg.det_en & (~stop_i | cfg.stop_en);
  assign lv_rst_req_o = lvd_s & det_live & cfg.rst_en;
  assign warn_irq_o   = warn_flag & cfg.irq_en;
  assign bg_buf_en_o  = cfg.bg_en;

  always_comb begin
    rdata_o = '0;
    if (sel_i && rd_i) begin
      rdata_o[B_FLAG]   = warn_flag;
      rdata_o[B_IRQEN]  = cfg.irq_en;
      rdata_o[B_RSTEN]  = cfg.rst_en;
      rdata_o[B_STOPEN] = cfg.stop_en;
      rdata_o[B_DETEN]  = cfg.det_en;
      rdata_o[B_BGEN]   = cfg.bg_en;
    end
  end
endmodule

// File: rtl/lvmon_chk.sv
module lvmon_chk
  import lvmon_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  lvw_s,
  input logic  ack_stb,
  input logic  lock,
  input logic  warn_flag,
  input ctrl_t cfg,
  input logic  stop_i,
  input logic  warn_irq_o,
  input logic  lv_rst_req_o,
  input logic  rd_b6,
  input logic  rd_b1
);
  AST_FLAG_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvw_s |=> warn_flag); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warn_flag && !(ack_stb && !lvw_s)) |=> warn_flag); // R3
  AST_ACK_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_stb && lvw_s) |=> warn_flag); // R4
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !warn_flag |-> !warn_irq_o); // R5
  AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |=> ($stable(cfg.det_en) && $stable(cfg.rst_en) && lock)); // R6
  AST_RST_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lv_rst_req_o |-> (cfg.det_en && cfg.rst_en)); // R7
  AST_STOP_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !cfg.stop_en) |-> !lv_rst_req_o); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_b6 && !rd_b1); // R10
endmodule

bind lvmon_ctrl lvmon_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lvw_s       (lvw_s),
  .ack_stb     (ack_stb),
  .lock        (lock),
  .warn_flag   (warn_flag),
  .cfg         (cfg),
  .stop_i      (stop_i),
  .warn_irq_o  (warn_irq_o),
  .lv_rst_req_o(lv_rst_req_o),
  .rd_b6       (rdata_o[6]),
  .rd_b1       (rdata_o[1])
);

// File: tb/test_lvmon_ctrl.sv
module test_lvmon_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       lvd_cmp_i = 1'b0, lvw_cmp_i = 1'b0, stop_i = 1'b0;
  logic       warn_irq_o, lv_rst_req_o, bg_buf_en_o;
  int         n_chk = 0, n_err = 0;
  logic       done = 1'b0;

  always #5 clk_i = ~clk_i;

  lvmon_ctrl i_lvmon_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .lvd_cmp_i(lvd_cmp_i),
    .lvw_cmp_i(lvw_cmp_i), .stop_i(stop_i), .warn_irq_o(warn_irq_o),
    .lv_rst_req_o(lv_rst_req_o), .bg_buf_en_o(bg_buf_en_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    cycles(2);
    rst_ni = 1'b1;
  endtask

  task automatic reg_wr(input logic [7:0] d);
    @(negedge clk_i);
    sel_i = 1'b1; wr_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    sel_i = 1'b0; wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic reg_rd(output logic [7:0] d);
    sel_i = 1'b1; rd_i = 1'b1;
    #1 d = rdata_o;
    sel_i = 1'b0; rd_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    reg_rd(v);
    check("R1 reset value", v, 8'h1C);
    check("R1 outputs", {5'd0, warn_irq_o, lv_rst_req_o, bg_buf_en_o}, 8'h00);
    sel_i = 1'b1; #1;
    check("R11 no read strobe", rdata_o, 8'h00);
    sel_i = 1'b0; rd_i = 1'b1; #1;
    check("R11 no select", rdata_o, 8'h00);
    rd_i = 1'b0;
  endtask

  task automatic t_warn();
    logic [7:0] v;
    do_reset();
    lvw_cmp_i = 1'b1;
    cycles(2);
    reg_rd(v);
    check("R12 flag not yet", {7'd0, v[7]}, 8'h00);
    cycles(1);
    reg_rd(v);
    check("R12 R2 flag on third edge", {7'd0, v[7]}, 8'h01);
    lvw_cmp_i = 1'b0;
    cycles(4);
    reg_rd(v);
    check("R3 flag sticky", {7'd0, v[7]}, 8'h01);
    check("R5 irq off while disabled", {7'd0, warn_irq_o}, 8'h00);
    reg_wr(8'h20);
    check("R5 irq on", {7'd0, warn_irq_o}, 8'h01);
    lvw_cmp_i = 1'b1;
    cycles(3);
    reg_wr(8'h60);
    reg_rd(v);
    check("R4 ack blocked while present", {7'd0, v[7]}, 8'h01);
    lvw_cmp_i = 1'b0;
    cycles(3);
    reg_wr(8'h60);
    reg_rd(v);
    check("R4 ack clears", {7'd0, v[7]}, 8'h00);
    check("R5 irq drops with flag", {7'd0, warn_irq_o}, 8'h00);
    reg_wr(8'hFF);
    reg_rd(v);
    check("R10 R9 write all ones", v, 8'h29);
    check("R9 bandgap on", {7'd0, bg_buf_en_o}, 8'h01);
    reg_wr(8'h00);
    reg_rd(v);
    check("R9 write zeros", v, 8'h00);
    check("R9 bandgap off", {7'd0, bg_buf_en_o}, 8'h00);
  endtask

  task automatic t_poweron_warn();
    logic [7:0] v;
    @(negedge clk_i);
    rst_ni = 1'b0;
    lvw_cmp_i = 1'b1;
    cycles(2);
    rst_ni = 1'b1;
    cycles(4);
    reg_rd(v);
    check("R2 warning present at reset release", {7'd0, v[7]}, 8'h01);
    lvw_cmp_i = 1'b0;
    cycles(3);
  endtask

  task automatic t_write_once();
    logic [7:0] v;
    do_reset();
    reg_wr(8'h00);
    reg_rd(v);
    check("R6 first write takes", v, 8'h00);
    reg_wr(8'h1C);
    reg_rd(v);
    check("R6 second write locked", v, 8'h08);
  endtask

  task automatic t_reset_req();
    do_reset();
    lvd_cmp_i = 1'b1;
    cycles(1);
    check("R12 req not after one edge", {7'd0, lv_rst_req_o}, 8'h00);
    cycles(1);
    check("R7 R12 req after two edges", {7'd0, lv_rst_req_o}, 8'h01);
    lvd_cmp_i = 1'b0;
    do_reset();
    reg_wr(8'h0C);
    lvd_cmp_i = 1'b1;
    cycles(3);
    check("R7 no req without reset enable", {7'd0, lv_rst_req_o}, 8'h00);
    lvd_cmp_i = 1'b0;
    do_reset();
    reg_wr(8'h18);
    lvd_cmp_i = 1'b1;
    cycles(3);
    check("R7 no req without detect enable", {7'd0, lv_rst_req_o}, 8'h00);
    lvd_cmp_i = 1'b0;
  endtask

  task automatic t_stop();
    do_reset();
    stop_i = 1'b1;
    lvd_cmp_i = 1'b1;
    cycles(3);
    check("R8 stop with stop enable", {7'd0, lv_rst_req_o}, 8'h01);
    lvd_cmp_i = 1'b0;
    do_reset();
    reg_wr(8'h14);
    lvd_cmp_i = 1'b1;
    cycles(3);
    check("R8 stop masks detect", {7'd0, lv_rst_req_o}, 8'h00);
    stop_i = 1'b0; #1;
    check("R8 run mode ignores stop enable", {7'd0, lv_rst_req_o}, 8'h01);
    lvd_cmp_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    t_reset();
    t_warn();
    t_poweron_warn();
    t_write_once();
    t_reset_req();
    t_stop();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end
endmodule